// File: doc/BRIEF.md
# Inter-Processor Doorbell Unit

This unit lets software on any processor ring a doorbell on one or more processors at once. A single write to the trigger register in the shared register space carries a bitmap of target processors and a doorbell number. Each processor in the bitmap gets the matching bit set in its own pending-doorbell register. Each processor also owns an enable register. The unit ORs the pending bits that are enabled into one registered request line for that processor. That line feeds the lowest-numbered source of the interrupt controller.

A processor's handler reads its pending register and services the set bits from doorbell 0 up to doorbell 7. It then acknowledges them by writing to the pending register. A data bit of 0 clears the matching pending bit, so writing zero clears every doorbell for that processor. Shared-space and private-space writes arrive on separate ports, so one processor can acknowledge in the same cycle that another rings. In that case the new doorbell is kept. The number of processors is a parameter, from 1 to 8.

Top module: `doorbell_unit`

## Requirements
- R1: After reset every pending register and every enable register of every processor reads 0, and every request line is low.
- R2: A shared-space write to offset 0x4 is a trigger. Data bits [15:8] give the target bitmap, where bit 8+c selects processor c. Data bits [7:0] give the doorbell number. The write sets pending bit n in each selected processor in the next cycle and leaves unselected processors unchanged.
- R3: A trigger has no effect when its doorbell number is 8 or above. Bitmap bits for processor numbers at or above the processor count are also ignored.
- R4: A private write to offset 0x8 of processor c ANDs that processor's pending bits with data [7:0]. Writing 0 clears them all, and the other processors are unchanged.
- R5: A private write to offset 0xC of processor c loads its enable register from data [7:0], and the value reads back.
- R6: The request line of processor c is high exactly when, in the previous cycle, pending AND enable of processor c was nonzero. It therefore lags a register change by one cycle.
- R7: When a trigger and a pending-clear write reach the same processor in the same cycle, the triggered bit is set after the cycle.
- R8: Triggers accumulate. A new doorbell is ORed into the pending bits, and ringing an already pending doorbell leaves the register unchanged.
- R9: Reads return the pending register at offset 0x8 and the enable register at offset 0xC. Any other offset reads 0. Read data is combinational from rd_cpu and rd_offset.
- R10: A shared-space write to any offset other than 0x4 changes no pending register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_wr | input | 1 | Shared-space write strobe |
| glb_offset | input | 4 | Shared-space write offset |
| glb_data | input | 16 | Shared-space write data (target bitmap and doorbell number) |
| prv_wr | input | 1 | Private-space write strobe |
| prv_cpu | input | CPU_W | Processor whose private space is written |
| prv_offset | input | 4 | Private-space write offset |
| prv_data | input | 8 | Private-space write data |
| rd_cpu | input | CPU_W | Processor whose private space is read |
| rd_offset | input | 4 | Private-space read offset |
| rd_data | output | 8 | Read data |
| db_irq | output | NUM_CPUS | Registered per-processor doorbell request |

## Verification
A corrupted pending bit becomes visible on the read port in the cycle after the faulty write. It also shows on the processor's request line one cycle after that, provided the bit is enabled. A decode slip makes the wrong processor or the wrong doorbell bit show up on readback right after the trigger. Examples are a bitmap bit steered to a neighbour or an out-of-range doorbell number wrapping onto a real bit. A lost doorbell in a same-cycle trigger-and-clear shows as a zero pending register straight after that cycle, and the handler would never see that doorbell again.

// File: rtl/dbell_pkg.sv
package dbell_pkg;

    localparam int DB_COUNT  = 8;
    localparam int MAP_W     = 8;
    localparam int NUM_W     = 8;
    localparam int OFF_W     = 4;
    localparam int GLB_W     = MAP_W + NUM_W;

    localparam logic [OFF_W-1:0] OFF_TRIGGER = 4'h4;
    localparam logic [OFF_W-1:0] OFF_CAUSE   = 4'h8;
    localparam logic [OFF_W-1:0] OFF_MASK    = 4'hC;

    typedef logic [DB_COUNT-1:0] db_vec_t;

    typedef enum logic [1:0] {
        PRV_NONE  = 2'd0,
        PRV_CAUSE = 2'd1,
        PRV_MASK  = 2'd2
    } prv_kind_e;

    typedef struct packed {
        prv_kind_e kind;
        db_vec_t   data;
    } prv_req_t;

    typedef struct packed {
        logic               valid;
        logic [MAP_W-1:0]   targets;
        db_vec_t            bell;
    } trig_req_t;

    // One-hot doorbell bit for a number, empty when out of range
    function automatic db_vec_t db_onehot(input logic [NUM_W-1:0] num);
        db_vec_t v;
        v = '0;
        for (int i = 0; i < DB_COUNT; i++) begin
            if (num == NUM_W'(i)) v[i] = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/dbell_trig_decode.sv
module dbell_trig_decode
    import dbell_pkg::*;
#(
    parameter int NUM_CPUS = 4
) (
    input  logic                         glb_wr,
    input  logic [OFF_W-1:0]             glb_offset,
    input  logic [GLB_W-1:0]             glb_data,
    output db_vec_t [NUM_CPUS-1:0]       set_mat
);

    trig_req_t req;

    always_comb begin
        req.valid   = glb_wr && (glb_offset == OFF_TRIGGER);
        req.targets = glb_data[GLB_W-1:NUM_W];
        req.bell    = db_onehot(glb_data[NUM_W-1:0]);
    end

    generate
        for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
            always_comb begin
                set_mat[c] = (req.valid && req.targets[c]) ? req.bell : '0;
            end
        end
    endgenerate

endmodule

// File: rtl/dbell_prv_decode.sv
module dbell_prv_decode
    import dbell_pkg::*;
#(
    parameter int NUM_CPUS = 4,
    localparam int CPU_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
    input  logic                         prv_wr,
    input  logic [CPU_W-1:0]             prv_cpu,
    input  logic [OFF_W-1:0]             prv_offset,
    input  db_vec_t                      prv_data,
    output prv_req_t [NUM_CPUS-1:0]      req_vec
);

    prv_kind_e kind;

    always_comb begin
        kind = PRV_NONE;
        if (prv_wr) begin
            if (prv_offset == OFF_CAUSE)     kind = PRV_CAUSE;
            else if (prv_offset == OFF_MASK) kind = PRV_MASK;
        end
    end

    generate
        for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
            always_comb begin
                req_vec[c].data = prv_data;
                req_vec[c].kind = (prv_cpu == CPU_W'(c)) ? kind : PRV_NONE;
            end
        end
    endgenerate

endmodule

// File: rtl/dbell_cpu_slot.sv
module dbell_cpu_slot
    import dbell_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  db_vec_t  set_vec,
    input  prv_req_t req,
    output db_vec_t  cause_q,
    output db_vec_t  mask_q,
    output logic     irq_q
);

    db_vec_t cause_nxt;
    db_vec_t mask_nxt;

    always_comb begin
        cause_nxt = cause_q;
        if (req.kind == PRV_CAUSE) cause_nxt = cause_q & req.data;
        // new doorbells are applied after the clear so none is lost
        cause_nxt = cause_nxt | set_vec;
        mask_nxt  = (req.kind == PRV_MASK) ? req.data : mask_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= '0;
            mask_q  <= '0;
            irq_q   <= 1'b0;
        end else begin
            cause_q <= cause_nxt;
            mask_q  <= mask_nxt;
            irq_q   <= |(cause_q & mask_q);
        end
    end

endmodule

// File: rtl/dbell_read_mux.sv
module dbell_read_mux
    import dbell_pkg::*;
#(
    parameter int NUM_CPUS = 4,
    localparam int CPU_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
    input  logic [CPU_W-1:0]        rd_cpu,
    input  logic [OFF_W-1:0]        rd_offset,
    input  db_vec_t [NUM_CPUS-1:0]  cause_mat,
    input  db_vec_t [NUM_CPUS-1:0]  mask_mat,
    output db_vec_t                 rd_data
);

    always_comb begin
        rd_data = '0;
        for (int c = 0; c < NUM_CPUS; c++) begin
            if (rd_cpu == CPU_W'(c)) begin
                if (rd_offset == OFF_CAUSE)     rd_data = cause_mat[c];
                else if (rd_offset == OFF_MASK) rd_data = mask_mat[c];
            end
        end
    end

endmodule

// File: rtl/doorbell_unit.sv
module doorbell_unit
    import dbell_pkg::*;
#(
    parameter int NUM_CPUS = 4,
    localparam int CPU_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 glb_wr,
    input  logic [OFF_W-1:0]     glb_offset,
    input  logic [GLB_W-1:0]     glb_data,
    input  logic                 prv_wr,
    input  logic [CPU_W-1:0]     prv_cpu,
    input  logic [OFF_W-1:0]     prv_offset,
    input  logic [DB_COUNT-1:0]  prv_data,
    input  logic [CPU_W-1:0]     rd_cpu,
    input  logic [OFF_W-1:0]     rd_offset,
    output logic [DB_COUNT-1:0]  rd_data,
    output logic [NUM_CPUS-1:0]  db_irq
);

    db_vec_t  [NUM_CPUS-1:0] set_mat;
    prv_req_t [NUM_CPUS-1:0] req_vec;
    db_vec_t  [NUM_CPUS-1:0] cause_mat;
    db_vec_t  [NUM_CPUS-1:0] mask_mat;

    dbell_trig_decode #(.NUM_CPUS(NUM_CPUS)) trig_i (
        .glb_wr     (glb_wr),
        .glb_offset (glb_offset),
        .glb_data   (glb_data),
        .set_mat    (set_mat)
    );

    dbell_prv_decode #(.NUM_CPUS(NUM_CPUS)) prv_i (
        .prv_wr     (prv_wr),
        .prv_cpu    (prv_cpu),
        .prv_offset (prv_offset),
        .prv_data   (prv_data),
        .req_vec    (req_vec)
    );

    generate
        for (genvar c = 0; c < NUM_CPUS; c++) begin : g_slot
            dbell_cpu_slot slot_i (
                .clk     (clk),
                .rst     (rst),
                .set_vec (set_mat[c]),
                .req     (req_vec[c]),
                .cause_q (cause_mat[c]),
                .mask_q  (mask_mat[c]),
                .irq_q   (db_irq[c])
            );
        end
    endgenerate

    dbell_read_mux #(.NUM_CPUS(NUM_CPUS)) rd_i (
        .rd_cpu    (rd_cpu),
        .rd_offset (rd_offset),
        .cause_mat (cause_mat),
        .mask_mat  (mask_mat),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/dbell_unit_chk.sv
module dbell_unit_chk
    import dbell_pkg::*;
#(
    parameter int NUM_CPUS = 4,
    localparam int CPU_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    glb_wr,
    input logic [OFF_W-1:0]        glb_offset,
    input logic [GLB_W-1:0]        glb_data,
    input logic                    prv_wr,
    input logic [CPU_W-1:0]        prv_cpu,
    input logic [OFF_W-1:0]        prv_offset,
    input db_vec_t [NUM_CPUS-1:0]  cause_mat,
    input db_vec_t [NUM_CPUS-1:0]  mask_mat,
    input logic [NUM_CPUS-1:0]     db_irq
);

    logic ring_ok;
    assign ring_ok = glb_wr && (glb_offset == OFF_TRIGGER) && (glb_data[7:0] < 8'd8);

    generate
        for (genvar c = 0; c < NUM_CPUS; c++) begin : g_chk
            // R2
            trigger_sets_chk: assert property (@(posedge clk) disable iff (rst)
                (ring_ok && glb_data[8+c]) |=> cause_mat[c][$past(glb_data[2:0])]);

            // R3
            no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
                !(ring_ok && glb_data[8+c]) |=> ((cause_mat[c] & ~$past(cause_mat[c])) == '0));

            // R5
            mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
                !(prv_wr && prv_cpu == CPU_W'(c) && prv_offset == OFF_MASK)
                |=> $stable(mask_mat[c]));

            // R6
            irq_lag_chk: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> (db_irq[c] == $past(|(cause_mat[c] & mask_mat[c]))));

            // R7
            trigger_wins_chk: assert property (@(posedge clk) disable iff (rst)
                (ring_ok && glb_data[8+c] && prv_wr && prv_cpu == CPU_W'(c)
                 && prv_offset == OFF_CAUSE)
                |=> cause_mat[c][$past(glb_data[2:0])]);
        end
    endgenerate

endmodule

bind doorbell_unit dbell_unit_chk #(.NUM_CPUS(NUM_CPUS)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .glb_wr     (glb_wr),
    .glb_offset (glb_offset),
    .glb_data   (glb_data),
    .prv_wr     (prv_wr),
    .prv_cpu    (prv_cpu),
    .prv_offset (prv_offset),
    .cause_mat  (cause_mat),
    .mask_mat   (mask_mat),
    .db_irq     (db_irq)
);

// File: tb/doorbell_unit_tb_top.sv
module doorbell_unit_tb_top;

    localparam int NC    = 4;
    localparam int CPU_W = 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             glb_wr = 1'b0;
    logic [3:0]       glb_offset = '0;
    logic [15:0]      glb_data = '0;
    logic             prv_wr = 1'b0;
    logic [CPU_W-1:0] prv_cpu = '0;
    logic [3:0]       prv_offset = '0;
    logic [7:0]       prv_data = '0;
    logic [CPU_W-1:0] rd_cpu = '0;
    logic [3:0]       rd_offset = '0;
    logic [7:0]       rd_data;
    logic [NC-1:0]    db_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    doorbell_unit #(.NUM_CPUS(NC)) dut_i (
        .clk(clk), .rst(rst),
        .glb_wr(glb_wr), .glb_offset(glb_offset), .glb_data(glb_data),
        .prv_wr(prv_wr), .prv_cpu(prv_cpu), .prv_offset(prv_offset), .prv_data(prv_data),
        .rd_cpu(rd_cpu), .rd_offset(rd_offset), .rd_data(rd_data),
        .db_irq(db_irq)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic rd(input int cpu, input logic [3:0] off, output logic [7:0] v);
        rd_cpu = CPU_W'(cpu);
        rd_offset = off;
        #1;
        v = rd_data;
    endtask

    task automatic glb_write(input logic [3:0] off, input logic [15:0] d);
        @(negedge clk);
        glb_wr = 1'b1; glb_offset = off; glb_data = d;
        @(negedge clk);
        glb_wr = 1'b0;
    endtask

    task automatic prv_write(input int cpu, input logic [3:0] off, input logic [7:0] d);
        @(negedge clk);
        prv_wr = 1'b1; prv_cpu = CPU_W'(cpu); prv_offset = off; prv_data = d;
        @(negedge clk);
        prv_wr = 1'b0;
    endtask

    task automatic expect_causes(input string req, input logic [7:0] e0, input logic [7:0] e1,
                                 input logic [7:0] e2, input logic [7:0] e3);
        logic [7:0] v;
        logic [7:0] e [4];
        e = '{e0, e1, e2, e3};
        for (int c = 0; c < NC; c++) begin
            rd(c, 4'h8, v);
            check(req, $sformatf("pending cpu%0d", c), 32'(v), 32'(e[c]));
        end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int c = 0; c < NC; c++) begin
            rd(c, 4'h8, v);
            check("R1", "pending after reset", 32'(v), 0);
            rd(c, 4'hC, v);
            check("R1", "enable after reset", 32'(v), 0);
        end
        check("R1", "irq after reset", 32'(db_irq), 0);
    endtask

    task automatic t_mask_rw();
        logic [7:0] v;
        prv_write(0, 4'hC, 8'hFF);
        prv_write(1, 4'hC, 8'h5A);
        rd(0, 4'hC, v); check("R5", "enable cpu0", 32'(v), 32'hFF);
        rd(1, 4'hC, v); check("R5", "enable cpu1", 32'(v), 32'h5A);
        rd(2, 4'hC, v); check("R5", "enable cpu2 untouched", 32'(v), 0);
        rd(1, 4'h4, v); check("R9", "unmapped offset reads zero", 32'(v), 0);
    endtask

    task automatic t_trigger_multi();
        glb_write(4'h4, 16'h0503);
        expect_causes("R2", 8'h08, 8'h00, 8'h08, 8'h00);
        glb_write(4'h4, 16'h0106);
        expect_causes("R8", 8'h48, 8'h00, 8'h08, 8'h00);
        glb_write(4'h4, 16'h0103);
        expect_causes("R8", 8'h48, 8'h00, 8'h08, 8'h00);
    endtask

    task automatic t_irq();
        check("R6", "irq with enabled pending", 32'(db_irq), 32'b0001);
        prv_write(2, 4'hC, 8'h08);
        check("R6", "irq cpu2 one cycle late", 32'(db_irq[2]), 0);
        @(negedge clk);
        check("R6", "irq cpu2 after enable", 32'(db_irq[2]), 1);
    endtask

    task automatic t_ignore();
        glb_write(4'h4, 16'hF001);
        expect_causes("R3", 8'h48, 8'h00, 8'h08, 8'h00);
        glb_write(4'h4, 16'h0F09);
        expect_causes("R3", 8'h48, 8'h00, 8'h08, 8'h00);
        glb_write(4'h8, 16'h0F01);
        expect_causes("R10", 8'h48, 8'h00, 8'h08, 8'h00);
    endtask

    task automatic t_clear();
        prv_write(0, 4'h8, 8'h08);
        expect_causes("R4", 8'h08, 8'h00, 8'h08, 8'h00);
        prv_write(0, 4'h8, 8'h00);
        expect_causes("R4", 8'h00, 8'h00, 8'h08, 8'h00);
        check("R6", "irq cpu0 still high one cycle", 32'(db_irq[0]), 1);
        @(negedge clk);
        check("R6", "irq cpu0 falls", 32'(db_irq[0]), 0);
    endtask

    task automatic t_race();
        glb_write(4'h4, 16'h0205);
        expect_causes("R2", 8'h00, 8'h20, 8'h08, 8'h00);
        @(negedge clk);
        check("R6", "masked doorbell gives no irq", 32'(db_irq[1]), 0);
        @(negedge clk);
        glb_wr = 1'b1; glb_offset = 4'h4; glb_data = 16'h0202;
        prv_wr = 1'b1; prv_cpu = 2'd1; prv_offset = 4'h8; prv_data = 8'h00;
        @(negedge clk);
        glb_wr = 1'b0; prv_wr = 1'b0;
        expect_causes("R7", 8'h00, 8'h04, 8'h08, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_mask_rw();
        t_trigger_multi();
        t_irq();
        t_ignore();
        t_clear();
        t_race();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule